// File: doc/BRIEF.md
# Postincrement Memory Compare Unit

This unit carries out a compare of two memory operands, each found through an address register that is advanced after use. A one-cycle `start` pulse hands it an instruction word and a snapshot of the eight address registers. The unit then issues two reads on a synchronous memory read port. The source operand is read first and its register is advanced. The destination operand is read after that, and its register is advanced in turn. The unit sets N, Z, V and C from destination minus source, taken at the operand size. The difference is never stored, and the unit has no memory write path.

Because the source register is advanced before the destination address is taken, an instruction whose two fields name the same register compares two consecutive elements. That register then moves by twice the element size. The surrounding core writes `areg_out` back into its register file when `done` pulses, and uses `cycles` for its timing account. A size field of 11 is refused: `illegal` is raised, no read is made and every register is left as it came in.

Top module: `pcmp_unit`

## Requirements
- R1: The instruction word takes the destination register number from bits 11:9, the source register number from bits 2:0 and the size from bits 7:6 (00 byte, 01 word, 10 long, 11 illegal). All other bits have no effect.
- R2: The first read after `start` is at the source register's incoming value, and that register is then advanced by the increment.
- R3: The second and last read is at the destination register's value after the R2 update, and that register is then advanced by the increment. A legal operation makes exactly two reads, with the source read first.
- R4: The increment is 1 for byte, 2 for word and 4 for long. Register arithmetic wraps modulo 2^AW.
- R5: When both fields name the same register, the second read is at the first address plus the increment. The register ends advanced by twice the increment, and the flags compare the two consecutive elements.
- R6: The flags come from destination minus source at the operand size. N is the sign bit of the difference, Z is set when the difference is zero, V is signed overflow and C is the borrow (source greater than destination, unsigned).
- R7: Read data is left-aligned on `mem_rdata`: the byte at the read address is in bits 31:24, a word uses bits 31:16 and a long uses all 32 bits. Bits below the operand are ignored.
- R8: For a legal size, `done` is high for exactly one cycle, three rising edges after the edge that samples `start`. At that point `cycles` reads 12 for byte or word and 20 for long, and `areg_out` holds the updated registers.
- R9: An illegal size raises `done` and `illegal` one edge after `start`, makes no read, returns `areg_out` equal to `areg_in`, reports `cycles` as 0 and leaves the flags at their previous values.
- R10: A `start` pulse that arrives while an operation is in progress is ignored.
- R11: After reset, `done`, `illegal`, the flags, `cycles`, `mem_rd`, `mem_addr` and `areg_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation with `instr` and `areg_in` |
| instr | input | 16 | Instruction word |
| areg_in | input | 8*AW | Address registers; register k is in bits k*AW +: AW |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_rdata | input | 32 | Read data, valid one cycle after the request, left-aligned |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Size field was 11 (held until the next completion) |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Borrow |
| cycles | output | $clog2(CYC_LONG+1) | Cycle count of the completed operation |
| areg_out | output | 8*AW | Updated address registers |

## Verification
The bench builds the unit with AW = 12 and keeps the default cycle counts. A 12-bit address space fits a 4 KiB byte model in full, so a word read that starts at the top address wraps around to address 0. This wrap is exercised together with the register increment that wraps the same way. The narrow registers also let the bench compare every register, every read address and every flag against its own model after each operation. That model includes the same-register byte and long cases, signed overflow at word size and a refused size.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  localparam int NREG = 8;
  localparam int DW   = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  // Keeps the operand bits of a left-aligned data word.
  function automatic logic [DW-1:0] keep_mask(size_e sz);
    case (sz)
      SZ_BYTE: keep_mask = 32'hFF00_0000;
      SZ_WORD: keep_mask = 32'hFFFF_0000;
      default: keep_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pcmp_decode.sv
module pcmp_decode
  import pcmp_pkg::*;
(
  input  logic [15:0] instr,
  output logic [2:0]  src_idx,
  output logic [2:0]  dst_idx,
  output size_e       size,
  output logic        bad,
  output logic [2:0]  step
);
  logic unused_bits;
  assign unused_bits = ^{instr[15:12], instr[8], instr[5:3]};

  assign dst_idx = instr[11:9];
  assign src_idx = instr[2:0];
  assign size    = size_e'(instr[7:6]);
  assign bad     = (size == SZ_BAD);

  always_comb begin
    case (size)
      SZ_BYTE: step = 3'd1;
      SZ_WORD: step = 3'd2;
      SZ_LONG: step = 3'd4;
      default: step = 3'd0;
    endcase
  end
endmodule

// File: rtl/pcmp_flags.sv
module pcmp_flags
  import pcmp_pkg::*;
(
  input  size_e          size,
  input  logic [DW-1:0]  dst_raw,
  input  logic [DW-1:0]  src_raw,
  output logic           n,
  output logic           z,
  output logic           v,
  output logic           c
);
  logic [DW-1:0] d_al, s_al, r;
  logic [DW:0]   diff;

  // Operands stay left-aligned with low bits cleared, so the top bit of
  // the full-width difference is the sign at the operand size.
  assign d_al = dst_raw & keep_mask(size);
  assign s_al = src_raw & keep_mask(size);
  assign diff = {1'b0, d_al} - {1'b0, s_al};
  assign r    = diff[DW-1:0];

  assign n = r[DW-1];
  assign z = (r == '0);
  assign c = diff[DW];
  assign v = (d_al[DW-1] ^ s_al[DW-1]) & (r[DW-1] ^ d_al[DW-1]);
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
  import pcmp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CYC_SHORT = 12,
  parameter int CYC_LONG  = 20,
  localparam int CW       = $clog2(CYC_LONG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [15:0]        instr,
  input  logic [NREG*AW-1:0] areg_in,
  output logic               mem_rd,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               done,
  output logic               illegal,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_v,
  output logic               flag_c,
  output logic [CW-1:0]      cycles,
  output logic [NREG*AW-1:0] areg_out
);
  typedef enum logic [1:0] {ST_IDLE, ST_DST, ST_CAP, ST_FIN} state_e;

  state_e        state;
  logic [AW-1:0] ain   [NREG];
  logic [AW-1:0] areg_q[NREG];
  logic [2:0]    src_q, dst_q, inc_q;
  size_e         size_q;
  logic [DW-1:0] src_data;

  logic [2:0] d_src, d_dst, d_step;
  size_e      d_size;
  logic       d_bad;
  logic       fn, fz, fv, fc;
  logic [AW-1:0] step_w;

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    assign ain[g]               = areg_in[g*AW +: AW];
    assign areg_out[g*AW +: AW] = areg_q[g];
  end

  pcmp_decode u_dec (
    .instr   (instr),
    .src_idx (d_src),
    .dst_idx (d_dst),
    .size    (d_size),
    .bad     (d_bad),
    .step    (d_step)
  );

  pcmp_flags u_flg (
    .size    (size_q),
    .dst_raw (mem_rdata),
    .src_raw (src_data),
    .n       (fn),
    .z       (fz),
    .v       (fv),
    .c       (fc)
  );

  assign step_w = AW'(inc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      for (int i = 0; i < NREG; i++) areg_q[i] <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      inc_q    <= '0;
      size_q   <= SZ_BYTE;
      src_data <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_v   <= 1'b0;
      flag_c   <= 1'b0;
      cycles   <= '0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          for (int i = 0; i < NREG; i++) areg_q[i] <= ain[i];
          src_q  <= d_src;
          dst_q  <= d_dst;
          inc_q  <= d_step;
          size_q <= d_size;
          if (d_bad) begin
            done    <= 1'b1;
            illegal <= 1'b1;
            cycles  <= '0;
          end else begin
            illegal       <= 1'b0;
            mem_rd        <= 1'b1;
            mem_addr      <= ain[d_src];
            areg_q[d_src] <= ain[d_src] + AW'(d_step);
            state         <= ST_DST;
          end
        end
        ST_DST: begin
          // Source register already advanced: same-register case reads
          // the next element.
          mem_rd        <= 1'b1;
          mem_addr      <= areg_q[dst_q];
          areg_q[dst_q] <= areg_q[dst_q] + step_w;
          state         <= ST_CAP;
        end
        ST_CAP: begin
          src_data <= mem_rdata;
          state    <= ST_FIN;
        end
        default: begin
          flag_n <= fn;
          flag_z <= fz;
          flag_v <= fv;
          flag_c <= fc;
          cycles <= (size_q == SZ_LONG) ? CW'(CYC_LONG) : CW'(CYC_SHORT);
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcmp_unit_chk.sv
module pcmp_unit_chk
  import pcmp_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CYC_LONG = 20,
  localparam int CW      = $clog2(CYC_LONG + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          illegal,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v,
  input logic          flag_c,
  input logic [CW-1:0] cycles,
  input logic [2:0]    src_q,
  input logic [2:0]    dst_q,
  input logic [2:0]    inc_q,
  input size_e         size_q
);
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: long operations report the long cycle count
  a_r8_long_cycles: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && size_q == SZ_LONG) |-> cycles == CW'(CYC_LONG));

  // R9: a refused size makes no read
  a_r9_no_read: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (!mem_rd && !$past(mem_rd)));

  // R6: a zero difference has no sign, overflow or borrow
  a_r6_zero_clean: assert property (@(posedge clk) disable iff (rst)
    (done && flag_z) |-> (!flag_n && !flag_v && !flag_c));

  // R5: same register, second read is one element further on
  a_r5_same_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd) && src_q == dst_q) |->
      mem_addr == $past(mem_addr) + AW'(inc_q));

  // R3: exactly two reads back to back
  a_r3_two_reads: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);
endmodule

bind pcmp_unit pcmp_unit_chk #(.AW(AW), .CYC_LONG(CYC_LONG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .done     (done),
  .illegal  (illegal),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .cycles   (cycles),
  .src_q    (src_q),
  .dst_q    (dst_q),
  .inc_q    (inc_q),
  .size_q   (size_q)
);

// File: tb/sim_pcmp_unit.sv
module sim_pcmp_unit;
  localparam int AW   = 12;
  localparam int NREG = 8;
  localparam int MSZ  = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst, start;
  logic [15:0]        instr;
  logic [NREG*AW-1:0] areg_in, areg_out;
  logic               mem_rd;
  logic [AW-1:0]      mem_addr;
  logic [31:0]        mem_rdata;
  logic               done, illegal, flag_n, flag_z, flag_v, flag_c;
  logic [4:0]         cycles;

  pcmp_unit #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .areg_in(areg_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .cycles(cycles), .areg_out(areg_out)
  );

  logic [7:0] mem [MSZ];

  function automatic logic [31:0] rd32(logic [AW-1:0] a);
    rd32 = {mem[a], mem[AW'(a + 1)], mem[AW'(a + 2)], mem[AW'(a + 3)]};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rd32(mem_addr);

  typedef struct packed {
    logic [3:0]         nzvc;
    logic               ill;
    logic [4:0]         cyc;
    logic [NREG*AW-1:0] regs;
    logic [1:0]         nrd;
    logic [AW-1:0]      a0, a1;
  } exp_t;

  exp_t          exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] rd_log[$];
  logic [AW-1:0] A [NREG];
  logic [3:0]    last_nzvc;
  int            n_chk = 0, n_bad = 0;

  task automatic chk(bit ok, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // Monitor: pop one expected item per completion.
  always @(negedge clk) begin
    if (!rst && mem_rd) rd_log.push_back(mem_addr);
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({flag_n, flag_z, flag_v, flag_c} == e.nzvc, {t, " R6 nzvc"},
            {flag_n, flag_z, flag_v, flag_c}, e.nzvc);
        chk(illegal == e.ill, {t, " R9 illegal"}, illegal, e.ill);
        chk(cycles == e.cyc, {t, " R8 cycles"}, cycles, e.cyc);
        chk(areg_out == e.regs, {t, " R4 regs"}, areg_out, e.regs);
        chk(rd_log.size() == int'(e.nrd), {t, " R3 read count"},
            rd_log.size(), e.nrd);
        if (e.nrd == 2 && rd_log.size() == 2) begin
          chk(rd_log[0] == e.a0, {t, " R2 src addr"}, rd_log[0], e.a0);
          chk(rd_log[1] == e.a1, {t, " R3 dst addr"}, rd_log[1], e.a1);
        end
      end
      rd_log.delete();
    end
  end

  function automatic logic [15:0] mk(int dst, int sz, int src);
    mk = {4'hB, 3'(dst), 1'b1, 2'(sz), 3'b001, 3'(src)};
  endfunction

  // Driver: compute expectation from the requirements, push it, pulse start.
  task automatic predict(logic [15:0] ins, string tag);
    exp_t e;
    logic [AW-1:0] B [NREG];
    int sz, src, dst, w;
    longint sv, dv, res, mask;
    logic [31:0] sr, dr;
    sz  = int'(ins[7:6]);
    src = int'(ins[2:0]);
    dst = int'(ins[11:9]);
    for (int i = 0; i < NREG; i++) B[i] = A[i];
    e = '0;
    if (sz == 3) begin
      e.ill = 1'b1; e.cyc = 5'd0; e.nzvc = last_nzvc; e.nrd = 2'd0;
    end else begin
      w = 8 << sz;
      e.a0 = B[src];
      B[src] = AW'(B[src] + (1 << sz));
      e.a1 = B[dst];
      B[dst] = AW'(B[dst] + (1 << sz));
      sr = rd32(e.a0);
      dr = rd32(e.a1);
      sv = longint'(sr >> (32 - w));
      dv = longint'(dr >> (32 - w));
      mask = (longint'(1) << w) - 1;
      res = (dv - sv) & mask;
      e.nzvc[3] = res[w-1];
      e.nzvc[2] = (res == 0);
      e.nzvc[1] = (dv[w-1] != sv[w-1]) && (res[w-1] != dv[w-1]);
      e.nzvc[0] = (dv < sv);
      e.cyc = (sz == 2) ? 5'd20 : 5'd12;
      e.nrd = 2'd2;
      last_nzvc = e.nzvc;
    end
    for (int i = 0; i < NREG; i++) e.regs[i*AW +: AW] = B[i];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 0; i < NREG; i++) A[i] = B[i];
  endtask

  task automatic load_regs();
    for (int i = 0; i < NREG; i++) areg_in[i*AW +: AW] = A[i];
  endtask

  task automatic run(logic [15:0] ins, string tag);
    load_regs();
    predict(ins, tag);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = 8'((i * 7) + 3);
    for (int i = 0; i < NREG; i++) A[i] = '0;
    last_nzvc = 4'b0;
    rst = 1'b1; start = 1'b0; instr = '0; areg_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({done, illegal, flag_n, flag_z, flag_v, flag_c} == 6'b0,
        "R11 status", {done, illegal, flag_n, flag_z, flag_v, flag_c}, 0);
    chk(cycles == 0 && !mem_rd && mem_addr == 0, "R11 cycles/read",
        {cycles, mem_rd}, 0);
    chk(areg_out == '0, "R11 regs", areg_out, 0);

    // R6: equal bytes, distinct registers
    A[1] = 12'h010; A[2] = 12'h020;
    mem[12'h010] = 8'h33; mem[12'h020] = 8'h33;
    run(mk(2, 0, 1), "R6 equal byte");
    // R6: 0x00 - 0x01 gives N and C
    mem[12'h011] = 8'h01; mem[12'h021] = 8'h00;
    run(mk(2, 0, 1), "R6 borrow byte");
    // R6: word signed overflow 0x8000 - 0x0001
    A[3] = 12'h100; A[4] = 12'h200;
    {mem[12'h100], mem[12'h101]} = 16'h0001;
    {mem[12'h200], mem[12'h201]} = 16'h8000;
    run(mk(4, 1, 3), "R6 overflow word");
    // R7: long operands using all 32 bits
    A[3] = 12'h104; A[4] = 12'h204;
    {mem[12'h104], mem[12'h105], mem[12'h106], mem[12'h107]} = 32'h1234_5678;
    {mem[12'h204], mem[12'h205], mem[12'h206], mem[12'h207]} = 32'h1234_5679;
    run(mk(4, 2, 3), "R7 long");
    // R5: same register, equal consecutive bytes
    A[0] = 12'h300;
    mem[12'h300] = 8'h55; mem[12'h301] = 8'h55;
    run(mk(0, 0, 0), "R5 same equal");
    // R5: same register, unequal consecutive bytes
    mem[12'h302] = 8'h10; mem[12'h303] = 8'h20;
    run(mk(0, 0, 0), "R5 same unequal");
    // R5: same register, long steps by 8
    A[5] = 12'h400;
    run(mk(5, 2, 5), "R5 same long");
    // R9: refused size with odd other bits
    run(16'h7FC5, "R9 illegal");
    // R4: wrap at the top of the address space
    A[6] = 12'hFFF; A[7] = 12'h800;
    mem[12'hFFF] = 8'hAB; mem[12'h000] = 8'hCD;
    run(mk(7, 1, 6), "R4 wrap word");
    // R1: other instruction bits have no effect
    run({4'h0, 3'd2, 1'b0, 2'd1, 3'b110, 3'd1}, "R1 stray bits");
    // R10: second start while busy is ignored
    load_regs();
    predict(mk(4, 0, 3), "R10 busy");
    instr = mk(4, 0, 3); start = 1'b1;
    @(negedge clk);
    instr = 16'h00C0;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R10 pending", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule